// File: doc/BRIEF.md
# Frame-Terminated Hard-Decision Viterbi Decoder

This block recovers the data bits of a short frame that a rate-1/2, constraint-length-3 convolutional encoder produced. It receives one hard-decision symbol pair per accepted cycle. For each pair it forms the Hamming distance to every possible branch label of the four-state trellis. It then updates the four path metrics with add-compare-select and records one survivor decision bit per state for that trellis step.

The encoder is assumed to start in state 0 and to finish in state 0, because two zero tail bits close every frame. The decoder therefore needs no best-state search. Once the last pair of a frame is in, it walks the stored decisions backwards from state 0, one step per cycle, and fills a bit buffer. It then plays that buffer out in transmission order, one bit per cycle, and marks the end with a single-cycle done flag. A frame-start strobe opens each frame. It re-arms the metrics and drops whatever frame was in progress.

Top module: `hdv_viterbi_dec`

## Requirements
- R1: While reset is held and after it is released, dec_valid and dec_done stay low until a complete frame has been received.
- R2: The code is defined as follows. For data bit d, with d1 and d2 the two previous data bits, the first coded bit is d^d1^d2 and the second is d^d2. The first bit arrives on sym_data[1] and the second on sym_data[0]. A frame without errors decodes to exactly its data bits, including the two trailing zero bits.
- R3: The received pairs 11 10 10 00 10 01 11 00, in order, decode to 1 0 1 1 1 0 0 0.
- R4: A frame with single bit errors at least five trellis steps apart decodes to the transmitted data.
- R5: The first decoded bit appears FRAME_LEN clock edges after the edge that accepts the last pair of the frame. The FRAME_LEN bits then follow with dec_valid high on consecutive cycles, starting with the bit of the first trellis step.
- R6: dec_done is high for exactly one cycle. That cycle comes straight after the last dec_valid cycle, and dec_done is never high together with dec_valid.
- R7: Cycles with sym_valid low do not advance the trellis, so idle gaps between the pairs of a frame leave the decoded result unchanged.
- R8: Pairs presented while the decoder is tracing back or emitting bits are ignored.
- R9: frame_start discards any frame in progress and re-arms decoding. The cycle after it, dec_valid and dec_done are low.
- R10: At frame start, the metric of state 0 is 0 and the other three metrics are at the all-ones maximum. When two incoming paths have equal cost, the survivor comes from the predecessor with the lower state number. Under these rules the decoded bits match a maximum-likelihood reference, even for frames with several errors.
- R11: Path metrics saturate at the all-ones value and never wrap. Within a frame, the smallest of the four metrics never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Strobe that opens a new frame and re-arms the metrics |
| sym_valid | input | 1 | sym_data holds a received pair this cycle |
| sym_data | input | 2 | Hard-decision pair; bit 1 is the first coded bit |
| dec_valid | output | 1 | dec_bit carries a decoded bit |
| dec_bit | output | 1 | Decoded data bit, in transmission order |
| dec_done | output | 1 | One-cycle pulse after the last decoded bit |

## Verification
The bound checker watches the output handshake on every cycle. It checks that done is a lone pulse that follows a valid bit and never overlaps one, that a run of valid bits ends in done unless a frame start cut it short, and that a frame start silences the outputs on the next cycle. It also checks that the smallest path metric never drops within a frame, which would reveal a wrapping adder. Whether the decoded bits are correct can only be shown by the bench's scenarios: error-free and corrupted frames, the fixed corrected example, gapped input, ignored pairs during playback, aborted frames, and noisy frames compared with a behavioural maximum-likelihood decoder that applies the same tie rule.

// File: rtl/hdv_pkg.sv
package hdv_pkg;

  localparam int NSTATE = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COLLECT,
    PH_TRACE,
    PH_EMIT,
    PH_DONE
  } phase_t;

  // Coded pair emitted when leaving state pred = {d1, d2} with input din.
  function automatic logic [1:0] branch_code(input logic [1:0] pred, input logic din);
    return {din ^ pred[1] ^ pred[0], din ^ pred[0]};
  endfunction

endpackage

// File: rtl/hdv_branch_metric.sv
module hdv_branch_metric (
  input  logic [1:0]      sym,
  output logic [3:0][1:0] bm
);

  // Hamming distance between the received pair and each possible label.
  for (genvar c = 0; c < 4; c++) begin : g_label
    logic [1:0] diff;
    assign diff  = sym ^ 2'(c);
    assign bm[c] = {diff[1] & diff[0], diff[1] ^ diff[0]};
  end

endmodule

// File: rtl/hdv_acs.sv
module hdv_acs #(
  parameter int MW = 5
) (
  input  logic [3:0][MW-1:0] pm_cur,
  input  logic [3:0][1:0]    bm,
  output logic [3:0][MW-1:0] pm_nxt,
  output logic [3:0]         pick
);
  import hdv_pkg::*;

  localparam logic [MW-1:0] PM_MAX = '1;

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic [1:0] b);
    logic [MW:0] s;
    s = {1'b0, a} + (MW+1)'(b);
    return s[MW] ? PM_MAX : s[MW-1:0];
  endfunction

  // Next state {a, b} is reached from {b, 0} or {b, 1} with input a.
  for (genvar ns = 0; ns < NSTATE; ns++) begin : g_state
    localparam logic [1:0] P_LO = 2'((ns % 2) * 2);
    localparam logic [1:0] P_HI = 2'((ns % 2) * 2 + 1);
    localparam logic       DIN  = 1'((ns / 2) % 2);
    logic [MW-1:0] cost_lo, cost_hi;
    assign cost_lo    = sat_add(pm_cur[P_LO], bm[branch_code(P_LO, DIN)]);
    assign cost_hi    = sat_add(pm_cur[P_HI], bm[branch_code(P_HI, DIN)]);
    assign pick[ns]   = cost_hi < cost_lo;        // ties keep the lower predecessor
    assign pm_nxt[ns] = pick[ns] ? cost_hi : cost_lo;
  end

endmodule

// File: rtl/hdv_survivor_mem.sv
module hdv_survivor_mem #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_pick,
  input  logic [AW-1:0] rd_addr,
  output logic [3:0]    rd_pick
);

  logic [DEPTH-1:0][3:0] mem_q;

  // Datapath storage without reset: every entry is written before trace-back reads it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_pick;
    end
  end

  assign rd_pick = mem_q[rd_addr];

endmodule

// File: rtl/hdv_viterbi_dec.sv
module hdv_viterbi_dec #(
  parameter int FRAME_LEN = 8,
  parameter int MW        = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       sym_valid,
  input  logic [1:0] sym_data,
  output logic       dec_valid,
  output logic       dec_bit,
  output logic       dec_done
);
  import hdv_pkg::*;

  localparam int            SW      = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [SW-1:0] LAST    = SW'(FRAME_LEN - 1);
  localparam logic [MW-1:0] PM_MAX  = '1;
  localparam logic [3:0][MW-1:0] PM_INIT = {PM_MAX, PM_MAX, PM_MAX, {MW{1'b0}}};

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  phase_t                phase_q, phase_d;
  logic [SW-1:0]         step_q, step_d;
  logic [3:0][MW-1:0]    pm_q, pm_d;
  logic [1:0]            tb_state_q, tb_state_d;
  logic [FRAME_LEN-1:0]  buf_q, buf_d;

  logic [3:0][1:0]       bm;
  logic [3:0][MW-1:0]    acs_pm;
  logic [3:0]            acs_pick;
  logic [3:0]            rd_pick;
  logic                  accept;

  hdv_branch_metric u_bm (
    .sym (sym_data),
    .bm  (bm)
  );

  hdv_acs #(.MW(MW)) u_acs (
    .pm_cur (pm_q),
    .bm     (bm),
    .pm_nxt (acs_pm),
    .pick   (acs_pick)
  );

  hdv_survivor_mem #(.DEPTH(FRAME_LEN), .AW(SW)) u_surv (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (step_q),
    .wr_pick (acs_pick),
    .rd_addr (step_q),
    .rd_pick (rd_pick)
  );

  assign accept = (phase_q == PH_COLLECT) && sym_valid && !frame_start;

  always_comb begin
    phase_d    = phase_q;
    step_d     = step_q;
    pm_d       = pm_q;
    tb_state_d = tb_state_q;
    buf_d      = buf_q;
    if (frame_start) begin
      phase_d = PH_COLLECT;
      step_d  = '0;
      pm_d    = PM_INIT;
    end else begin
      case (phase_q)
        PH_COLLECT: begin
          if (sym_valid) begin
            pm_d = acs_pm;
            if (step_q == LAST) begin
              phase_d    = PH_TRACE;
              tb_state_d = 2'b00;           // terminated trellis ends in state 0
            end else begin
              step_d = step_q + 1'b1;
            end
          end
        end
        PH_TRACE: begin
          buf_d[step_q] = tb_state_q[1];    // newest bit of the state is this step's input
          tb_state_d    = {tb_state_q[0], rd_pick[tb_state_q]};
          if (step_q == '0) phase_d = PH_EMIT;
          else              step_d  = step_q - 1'b1;
        end
        PH_EMIT: begin
          if (step_q == LAST) phase_d = PH_DONE;
          else                step_d  = step_q + 1'b1;
        end
        PH_DONE: phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q    <= PH_IDLE;
      step_q     <= '0;
      pm_q       <= PM_INIT;
      tb_state_q <= 2'b00;
      buf_q      <= '0;
    end else begin
      phase_q    <= phase_d;
      step_q     <= step_d;
      pm_q       <= pm_d;
      tb_state_q <= tb_state_d;
      buf_q      <= buf_d;
    end
  end

  assign dec_valid = (phase_q == PH_EMIT);
  assign dec_bit   = (phase_q == PH_EMIT) ? buf_q[step_q] : 1'b0;
  assign dec_done  = (phase_q == PH_DONE);

endmodule

// File: rtl/hdv_checker.sv
module hdv_checker #(
  parameter int MW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               dec_valid,
  input logic               dec_done,
  input logic [3:0][MW-1:0] pm_q
);

  logic [MW-1:0] pm_min;
  always_comb begin
    pm_min = pm_q[0];
    for (int i = 1; i < 4; i++) begin
      if (pm_q[i] < pm_min) pm_min = pm_q[i];
    end
  end

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done);

  // R6: done never coincides with a valid bit
  a_r6_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_done));

  // R6: done follows the last valid bit
  a_r6_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> $past(dec_valid));

  // R5: a run of valid bits closes with done unless a new frame cut it off
  a_r5_run_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dec_valid) |-> (dec_done || $past(frame_start)));

  // R9: frame start silences the outputs on the next cycle
  a_r9_start_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!dec_valid && !dec_done));

  // R11: saturating metrics never wrap below the previous minimum
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> (pm_min >= $past(pm_min)));

endmodule

bind hdv_viterbi_dec hdv_checker #(.MW(MW)) u_hdv_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .dec_valid   (dec_valid),
  .dec_done    (dec_done),
  .pm_q        (pm_q)
);

// File: tb/hdv_viterbi_dec_test.sv
module hdv_viterbi_dec_test;

  localparam int N    = 8;
  localparam int MW   = 5;
  localparam int MAXV = (1 << MW) - 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start;
  logic       sym_valid;
  logic [1:0] sym_data;
  logic       dec_valid, dec_bit, dec_done;

  always #2 clk = ~clk;   // 250 MHz

  hdv_viterbi_dec #(.FRAME_LEN(N), .MW(MW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sym_valid   (sym_valid),
    .sym_data    (sym_data),
    .dec_valid   (dec_valid),
    .dec_bit     (dec_bit),
    .dec_done    (dec_done)
  );

  int           n_cmp = 0;
  int           n_bad = 0;
  bit           mon_on = 0;
  bit           armed = 0;
  int           cnt = 0;
  logic [N-1:0] exp_bits = '0;
  string        cur_req = "R1";
  bit           finished = 0;
  logic [15:0]  lfsr = 16'hACE1;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Transmission order written left to right.
  function automatic logic [N-1:0] bits_msb(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int t = 0; t < N; t++) r[t] = v[N-1-t];
    return r;
  endfunction

  function automatic logic [N-1:0][1:0] pairs_msb(input logic [2*N-1:0] v);
    logic [N-1:0][1:0] r;
    for (int t = 0; t < N; t++) r[t] = v[2*N-1-2*t -: 2];
    return r;
  endfunction

  // R2: behavioural encoder, first bit d^d1^d2, second d^d2.
  function automatic logic [N-1:0][1:0] encode(input logic [N-1:0] d);
    logic [N-1:0][1:0] r;
    logic s1, s2;
    s1 = 1'b0;
    s2 = 1'b0;
    for (int t = 0; t < N; t++) begin
      r[t] = {d[t] ^ s1 ^ s2, d[t] ^ s2};
      s2 = s1;
      s1 = d[t];
    end
    return r;
  endfunction

  // R10: maximum-likelihood reference with integer metrics and the lower-state tie rule.
  function automatic logic [N-1:0] ref_decode(input logic [N-1:0][1:0] rx);
    int pm [4];
    int nm [4];
    bit [3:0] surv [N];
    logic [N-1:0] out;
    int st;
    pm[0] = 0; pm[1] = MAXV; pm[2] = MAXV; pm[3] = MAXV;
    for (int t = 0; t < N; t++) begin
      for (int ns = 0; ns < 4; ns++) begin
        int a, b, c0, c1;
        a = ns / 2;
        b = ns % 2;
        c0 = pm[2*b]     + int'(rx[t][1] != 1'((a ^ b)))     + int'(rx[t][0] != 1'(a));
        c1 = pm[2*b + 1] + int'(rx[t][1] != 1'((a ^ b ^ 1))) + int'(rx[t][0] != 1'((a ^ 1)));
        if (c0 > MAXV) c0 = MAXV;
        if (c1 > MAXV) c1 = MAXV;
        if (c1 < c0) begin
          nm[ns] = c1;
          surv[t][ns] = 1'b1;
        end else begin
          nm[ns] = c0;
          surv[t][ns] = 1'b0;
        end
      end
      for (int s = 0; s < 4; s++) pm[s] = nm[s];
    end
    st = 0;
    for (int t = N - 1; t >= 0; t--) begin
      out[t] = 1'(st / 2);
      st = (st % 2) * 2 + int'(surv[t][st]);
    end
    return out;
  endfunction

  // Cycle-by-cycle comparison against the expected output schedule (R5, R6).
  always @(negedge clk) begin
    if (mon_on) begin
      logic ev, ed, eb;
      ev = armed && (cnt >= N) && (cnt < 2 * N);
      ed = armed && (cnt == 2 * N);
      eb = ev ? exp_bits[cnt - N] : 1'b0;
      n_cmp++;
      if (dec_valid !== ev || dec_done !== ed || (ev && dec_bit !== eb)) begin
        n_bad++;
        $display("FAIL %s R5/R6 cycle %0d: valid=%0b done=%0b bit=%0b expected valid=%0b done=%0b bit=%0b",
                 cur_req, cnt, dec_valid, dec_done, dec_bit, ev, ed, eb);
      end
      if (armed) begin
        if (cnt == 2 * N) armed = 0;
        else              cnt++;
      end
    end
  end

  task automatic run_frame(input logic [N-1:0][1:0] rx, input logic [N-1:0] expv,
                           input string req, input int gap, input bit junk_after);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    for (int t = 0; t < N; t++) begin
      sym_valid = 1'b1;
      sym_data  = rx[t];
      tick();
      if (gap > 0 && t < N - 1) begin
        sym_valid = 1'b0;
        sym_data  = ~rx[t];
        repeat (gap) tick();
      end
    end
    sym_valid = 1'b0;
    exp_bits  = expv;
    cur_req   = req;
    cnt       = 0;
    armed     = 1;
    if (junk_after) begin
      for (int k = 0; k < 2 * N; k++) begin
        lfsr      = lfsr_next(lfsr);
        sym_valid = 1'b1;
        sym_data  = lfsr[1:0];
        tick();
      end
      sym_valid = 1'b0;
    end
    while (armed) tick();
    repeat (2) tick();
  endtask

  initial begin
    logic [N-1:0]      d;
    logic [N-1:0][1:0] rx;
    rst_n       = 1'b0;
    frame_start = 1'b0;
    sym_valid   = 1'b0;
    sym_data    = 2'b00;
    tick();
    mon_on = 1;
    repeat (3) tick();
    n_cmp++;
    if (dec_valid !== 1'b0 || dec_done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: valid=%0b done=%0b expected 0 0", dec_valid, dec_done);
    end
    rst_n = 1'b1;
    repeat (6) tick();   // R1: monitor expects quiet outputs here

    // R2: error-free frames
    d = bits_msb(8'b10111000);
    rx = encode(d);
    n_cmp++;
    if (rx !== pairs_msb(16'b11_10_00_01_10_01_11_00)) begin
      n_bad++;
      $display("FAIL R2 bench encoder: got %h expected %h", rx, pairs_msb(16'b11_10_00_01_10_01_11_00));
    end
    run_frame(rx, d, "R2", 0, 0);
    d = bits_msb(8'b01101100);  run_frame(encode(d), d, "R2", 0, 0);
    d = bits_msb(8'b11111100);  run_frame(encode(d), d, "R2", 0, 0);
    d = bits_msb(8'b00000000);  run_frame(encode(d), d, "R2", 0, 0);

    // R3: the corrected example
    run_frame(pairs_msb(16'b11_10_10_00_10_01_11_00), bits_msb(8'b10111000), "R3", 0, 0);

    // R4: well-separated single errors
    d = bits_msb(8'b10111000);
    rx = encode(d);
    rx[1][1] = ~rx[1][1];
    rx[6][0] = ~rx[6][0];
    run_frame(rx, d, "R4", 0, 0);
    d = bits_msb(8'b01101100);
    rx = encode(d);
    rx[3][0] = ~rx[3][0];
    run_frame(rx, d, "R4", 0, 0);

    // R7: idle gaps between pairs
    d = bits_msb(8'b11010100);
    run_frame(encode(d), d, "R7", 2, 0);

    // R8: pairs offered during trace-back and playback are ignored
    d = bits_msb(8'b10011000);
    run_frame(encode(d), d, "R8", 0, 1);

    // R9: an aborted partial frame leaves no trace
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    for (int t = 0; t < 3; t++) begin
      sym_valid = 1'b1;
      sym_data  = 2'b11;
      tick();
    end
    sym_valid = 1'b0;
    d = bits_msb(8'b01011100);
    run_frame(encode(d), d, "R9", 0, 0);

    // R10: noisy frames against the reference decoder
    for (int f = 0; f < 8; f++) begin
      lfsr = lfsr_next(lfsr);
      d = lfsr[N-1:0];
      d[N-1] = 1'b0;
      d[N-2] = 1'b0;
      rx = encode(d);
      for (int e = 0; e < 3; e++) begin
        int pos;
        lfsr = lfsr_next(lfsr);
        pos = int'(lfsr[3:0]) % (2 * N);
        rx[pos / 2][pos % 2] = ~rx[pos / 2][pos % 2];
      end
      run_frame(rx, ref_decode(rx), "R10", 0, 0);
    end

    // R11: every bit inverted drives the metrics to their largest values
    d = bits_msb(8'b10111000);
    rx = ~encode(d);
    run_frame(rx, ref_decode(rx), "R11", 0, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule